// File: doc/BRIEF.md
# Serial configuration frame receiver

This block accepts a configuration bitstream arriving one bit per clock and splits it into a header, a fixed number of fixed-length data frames and a closing postamble. The header carries a length count, which is the number of bits the whole load is expected to contain. Each frame has a trailing four-bit check field. When checking is enabled, that field is compared with a CRC computed over the frame's data bits.

Every frame that is accepted is presented as a parallel data word together with a one-cycle valid strobe. When the load completes cleanly, a done flag is raised. A failed check, a malformed gap between frames or a wrong total length drives the active-low error output low. The block then stays in a wait state, ignoring all input, until a synchronous reset.

Top module: `cfg_frame_rx`

## Requirements
- R1: After a synchronous reset `err_n` is 1, `load_done` is 0 and `frame_valid` is 0. Reset is the only way out of the error state.
- R2: While waiting for the header, one-bits are skipped as padding and still counted toward the total. The header starts at the first zero bit and is 40 bits long. Bit 0 is that zero, bits 1 to 24 carry the 24-bit length count with the most significant bit first, and bits 25 to 39 are ignored.
- R3: A frame is one zero start bit, then DATA_BITS data bits, then 4 check bits. `frame_data` holds the data bits with the first received bit in the MSB. `frame_valid` pulses for exactly one cycle, in the cycle after the last check bit.
- R4: With `chk_en` = 1, the check bits, sent bit 3 first, must equal the low 4 bits of a CRC-16 with polynomial 0x8005 (x^16+x^15+x^2+1). The CRC register is cleared at the start bit and fed the data bits. On a mismatch no valid pulse is given and `err_n` falls in the cycle after the last check bit.
- R5: With `chk_en` = 0, the check bits are ignored, and one-bits arriving where a start bit is expected are skipped as padding that counts toward the total.
- R6: With `chk_en` = 1, a one-bit arriving where a start bit is expected drives `err_n` low.
- R7: After NUM_FRAMES frames come POST_BITS postamble bits, whose values are ignored. After the last of them, `load_done` rises if the number of accepted bits since reset equals the length count. Otherwise `err_n` falls.
- R8: A cycle with `bit_en` = 0 consumes no bit and changes no state.
- R9: Once error or done is reached, further bits have no effect: no frames are emitted and both flags hold until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bit_in | input | 1 | Serial bitstream |
| bit_en | input | 1 | Qualifies `bit_in` in this cycle |
| chk_en | input | 1 | Enables frame check comparison |
| frame_data | output | DATA_BITS | Data bits of the last accepted frame |
| frame_valid | output | 1 | One-cycle strobe for `frame_data` |
| load_done | output | 1 | Load finished with matching length |
| err_n | output | 1 | Low while in the error wait state |

## Verification
The hardest situation to reach is a length-count mismatch. It only shows up after a complete, otherwise valid load with every frame passing its check, so the stimulus builds a full stream and offsets the header's length field by one. Padding with checking disabled is also awkward to reach. The bench places one-bits ahead of every frame, corrupts the check fields and still expects every frame and the done flag, with the count including the padding. Idle cycles with the enable low are mixed into one load to show that gaps are not counted.

// File: rtl/cfg_frame_rx.sv
module cfg_frame_rx #(
  parameter int DATA_BITS  = 16,
  parameter int NUM_FRAMES = 4,
  parameter int POST_BITS  = 8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 bit_in,
  input  logic                 bit_en,
  input  logic                 chk_en,
  output logic [DATA_BITS-1:0] frame_data,
  output logic                 frame_valid,
  output logic                 load_done,
  output logic                 err_n
);
  localparam int LEN_W = 24;
  localparam int HDR_BITS = 40;
  localparam int MAXB = (DATA_BITS > POST_BITS) ? ((DATA_BITS > HDR_BITS) ? DATA_BITS : HDR_BITS)
                                                 : ((POST_BITS > HDR_BITS) ? POST_BITS : HDR_BITS);
  localparam int CW = $clog2(MAXB + 1);
  localparam int FW = $clog2(NUM_FRAMES + 1);

  typedef enum logic [2:0] {
    S_IDLE, S_HDR, S_WSTART, S_DATA, S_CHECK, S_POST, S_DONE, S_ERR
  } st_t;

  st_t                  st;
  logic [CW-1:0]        cnt;
  logic [FW-1:0]        nfr;
  logic [LEN_W-1:0]     total, len_q;
  logic [15:0]          crc;
  logic [2:0]           chk;
  logic [DATA_BITS-1:0] sh;

  wire        fb       = bit_in ^ crc[15];
  wire [15:0] crc_next = {crc[14:0], 1'b0} ^ ({16{fb}} & 16'h8005);
  wire        active   = (st != S_DONE) && (st != S_ERR);

  assign load_done = (st == S_DONE);
  assign err_n     = (st != S_ERR);

  always_ff @(posedge clk) begin
    if (rst) begin
      st          <= S_IDLE;
      cnt         <= '0;
      nfr         <= '0;
      total       <= '0;
      len_q       <= '0;
      crc         <= '0;
      chk         <= '0;
      sh          <= '0;
      frame_data  <= '0;
      frame_valid <= 1'b0;
    end else begin
      frame_valid <= 1'b0;
      if (bit_en && active) total <= total + 1'b1;
      if (bit_en) begin
        case (st)
          S_IDLE:
            if (!bit_in) begin
              st  <= S_HDR;
              cnt <= CW'(1);
            end
          S_HDR: begin
            if (cnt <= CW'(LEN_W)) len_q <= {len_q[LEN_W-2:0], bit_in};
            cnt <= cnt + 1'b1;
            if (cnt == CW'(HDR_BITS - 1)) begin
              st  <= S_WSTART;
              cnt <= '0;
            end
          end
          S_WSTART:
            if (!bit_in) begin
              st  <= S_DATA;
              crc <= '0;
              cnt <= '0;
            end else if (chk_en) begin
              st <= S_ERR;
            end
          S_DATA: begin
            sh  <= {sh[DATA_BITS-2:0], bit_in};
            crc <= crc_next;
            cnt <= cnt + 1'b1;
            if (cnt == CW'(DATA_BITS - 1)) begin
              st  <= S_CHECK;
              cnt <= '0;
            end
          end
          S_CHECK: begin
            chk <= {chk[1:0], bit_in};
            cnt <= cnt + 1'b1;
            if (cnt == CW'(3)) begin
              cnt <= '0;
              if (chk_en && ({chk, bit_in} != crc[3:0])) begin
                st <= S_ERR;
              end else begin
                frame_valid <= 1'b1;
                frame_data  <= sh;
                nfr         <= nfr + 1'b1;
                st          <= (nfr == FW'(NUM_FRAMES - 1)) ? S_POST : S_WSTART;
              end
            end
          end
          S_POST: begin
            cnt <= cnt + 1'b1;
            if (cnt == CW'(POST_BITS - 1))
              st <= (len_q == total + 1'b1) ? S_DONE : S_ERR;
          end
          default: ;
        endcase
      end
    end
  end

  AST_RESET_CLEAN:   assert property (@(posedge clk) rst |=> (err_n && !load_done && !frame_valid)); // R1
  AST_VALID_PULSE:   assert property (@(posedge clk) disable iff (rst) frame_valid |=> !frame_valid); // R3
  AST_ERR_HOLDS:     assert property (@(posedge clk) disable iff (rst) !err_n |=> !err_n); // R9
  AST_DONE_HOLDS:    assert property (@(posedge clk) disable iff (rst) load_done |=> load_done); // R9
  AST_QUIET_IN_ERR:  assert property (@(posedge clk) disable iff (rst) !err_n |-> !frame_valid); // R4
  AST_FRAME_LIMIT:   assert property (@(posedge clk) disable iff (rst) nfr <= FW'(NUM_FRAMES)); // R7
  AST_IDLE_HOLD:     assert property (@(posedge clk) disable iff (rst) (!bit_en && active) |=> $stable(total)); // R8
endmodule

// File: tb/cfg_frame_rx_tb.sv
`timescale 1ns/1ps
module cfg_frame_rx_tb;
  localparam int DB = 16, NF = 4, PB = 8;

  logic clk = 1'b0, rst = 1'b1, bit_in = 1'b1, bit_en = 1'b0, chk_en = 1'b1;
  logic [DB-1:0] frame_data;
  logic frame_valid, load_done, err_n;
  int n_chk = 0, n_bad = 0, ncap = 0;
  logic [DB-1:0] cap [0:15];

  always #2 clk = ~clk;

  cfg_frame_rx #(.DATA_BITS(DB), .NUM_FRAMES(NF), .POST_BITS(PB)) u_dut (
    .clk(clk), .rst(rst), .bit_in(bit_in), .bit_en(bit_en), .chk_en(chk_en),
    .frame_data(frame_data), .frame_valid(frame_valid), .load_done(load_done), .err_n(err_n));

  always @(negedge clk) if (frame_valid && ncap < 16) begin cap[ncap] = frame_data; ncap++; end

  task automatic check(input string req, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic logic [15:0] word(input int f, input int seed);
    return 16'hA5C3 ^ 16'(f * 16'h1357) ^ 16'(seed);
  endfunction

  function automatic logic [3:0] crc4(input logic [DB-1:0] d);
    logic [15:0] c = '0;
    for (int i = DB - 1; i >= 0; i--) begin
      logic f = d[i] ^ c[15];
      c = {c[14:0], 1'b0} ^ (f ? 16'h8005 : 16'h0000);
    end
    return c[3:0];
  endfunction

  task automatic send_bit(input logic b, input bit gap);
    @(negedge clk); bit_in = b; bit_en = 1'b1;
    @(posedge clk); #1;
    bit_en = 1'b0;
    if (gap) begin @(posedge clk); #1; end
  endtask

  task automatic do_reset;
    @(negedge clk); rst = 1'b1; bit_en = 1'b0;
    @(posedge clk); @(posedge clk); #1;
    rst = 1'b0; ncap = 0;
  endtask

  task automatic send_load(input int lead, input int pad, input int bad, input int adj,
                           input int seed, input bit gaps);
    int len = lead + 40 + NF * (pad + 1 + DB + 4) + PB + adj;
    int k = 0;
    for (int i = 0; i < lead; i++) send_bit(1'b1, 1'b0);
    send_bit(1'b0, 1'b0);
    for (int i = 23; i >= 0; i--) send_bit(len[i], gaps && (i % 5 == 0));
    for (int i = 25; i < 40; i++) send_bit(i[0], 1'b0);
    for (int f = 0; f < NF; f++) begin
      logic [DB-1:0] w = word(f, seed);
      logic [3:0] c = crc4(w) ^ ((f == bad) ? 4'b0100 : 4'b0000);
      for (int p = 0; p < pad; p++) send_bit(1'b1, 1'b0);
      send_bit(1'b0, 1'b0);
      for (int i = DB - 1; i >= 0; i--) begin send_bit(w[i], gaps && (k % 7 == 3)); k++; end
      for (int i = 3; i >= 0; i--) send_bit(c[i], 1'b0);
    end
    for (int i = 0; i < PB; i++) send_bit(i[1], 1'b0);
  endtask

  task automatic t_reset;
    do_reset;
    check("R1 err_n after reset", err_n, 1);
    check("R1 done after reset", load_done, 0);
    check("R1 valid after reset", frame_valid, 0);
  endtask

  task automatic t_normal(input int lead, input bit gaps, input int seed);
    do_reset; chk_en = 1'b1;
    send_load(lead, 0, -1, 0, seed, gaps);
    check("R3 frame count", ncap, NF);
    for (int f = 0; f < NF; f++) check("R3 R4 frame data", cap[f], word(f, seed));
    check("R7 R2 R8 done", load_done, 1);
    check("R2 err_n high", err_n, 1);
    send_bit(1'b0, 1'b0); send_bit(1'b0, 1'b0);
    check("R9 done holds", load_done, 1);
    check("R9 no frame after done", ncap, NF);
  endtask

  task automatic t_bad_crc;
    do_reset; chk_en = 1'b1;
    send_load(1, 0, 1, 0, 77, 1'b0);
    check("R4 err_n low on bad check", err_n, 0);
    check("R4 R9 frames before error", ncap, 1);
    check("R9 no done in error", load_done, 0);
    do_reset;
    check("R1 reset leaves error", err_n, 1);
  endtask

  task automatic t_chk_off;
    do_reset; chk_en = 1'b0;
    send_load(2, 3, 2, 0, 9, 1'b0);
    check("R5 all frames accepted", ncap, NF);
    check("R5 bad-check frame data", cap[2], word(2, 9));
    check("R5 padding counted done", load_done, 1);
    check("R5 err_n high", err_n, 1);
    chk_en = 1'b1;
  endtask

  task automatic t_len_bad;
    do_reset; chk_en = 1'b1;
    send_load(0, 0, -1, 1, 5, 1'b0);
    check("R7 frames on length mismatch", ncap, NF);
    check("R7 err_n low on mismatch", err_n, 0);
    check("R7 no done on mismatch", load_done, 0);
  endtask

  task automatic t_pad_strict;
    do_reset; chk_en = 1'b1;
    send_load(0, 1, -1, 0, 3, 1'b0);
    check("R6 pad with check on errors", err_n, 0);
    check("R6 no frames", ncap, 0);
  endtask

  initial begin
    #800000;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk + 1, n_bad);
    $finish;
  end

  initial begin
    t_reset;
    t_normal(3, 1'b1, 11);
    t_normal(0, 1'b0, 200);
    t_bad_crc;
    t_chk_off;
    t_len_bad;
    t_pad_strict;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule